// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block holds the digital control for a successive approximation converter. An accepted start loads the working register with only its top bit set. That value is the trial code, and it goes to an external comparator. On each clock the comparator's answer fixes the bit under test, and the next lower bit becomes the new trial. The word is therefore resolved from the most significant bit down to the least significant bit, one bit per cycle.

The register is shown on an output on every cycle, together with a per-bit mask of the positions that are already final. Downstream logic can therefore act on the leading bits before the whole word exists. A done flag rises with the last bit. It stays up until the next accepted start or an explicit clear. The sampling capacitors, the reference DAC and the comparator sit outside the block.

Top module: `sarSequencer`

## Requirements
- R1: The word width is a parameter, `WIDTH`, with a default of 12 bits.
- R2: A start while idle is accepted at that clock edge. After that edge `partialCode` holds only bit WIDTH-1 set, `validMask` is zero, `busy` is 1 and `done` is 0.
- R3: One bit is resolved per cycle, strictly from bit WIDTH-1 down to bit 0. Each resolution adds exactly one mask bit, and that bit is the highest one not yet set.
- R4: The resolved bit takes the value of `cmpAbove`, where 1 means the analog input is at or above `trialCode`. `trialCode` always equals `partialCode`.
- R5: After a bit other than bit 0 is fixed, the next lower bit is set to 1 as the new trial.
- R6: A bit whose mask bit is set never changes until the next accepted start.
- R7: A start pulse while `busy` is 1 is ignored. The conversion in progress continues unchanged.
- R8: `done` rises exactly WIDTH clock edges after the edge that accepted the start. At that point `busy` falls, `validMask` is all ones and `partialCode` equals the converted input.
- R9: Once set, `done` stays 1 until an accepted start or `clearDone`.
- R10: `clearDone` drops `done` on the next edge and leaves `partialCode` and `validMask` unchanged.
- R11: After reset, `partialCode`, `validMask`, `busy` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Request to begin a conversion |
| clearDone | input | 1 | Drops the done flag |
| cmpAbove | input | 1 | Comparator answer: input is at or above the trial code |
| trialCode | output | WIDTH | Code presented to the reference DAC |
| partialCode | output | WIDTH | Working register, readable on every cycle |
| validMask | output | WIDTH | 1 for each bit already final |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Completion flag |

## Verification
A wrong bit index or a wrong comparator latch corrupts `partialCode` on the very next cycle. Because the bench compares the working register and the mask on every cycle, such an error is reported one cycle after it happens, not when the word completes. A miscounted sequence moves the rise of `done` by at least one cycle, or leaves a zero in `validMask`, so the completion check catches it. A start that is wrongly honoured during a conversion reloads the register to the top bit alone, and the following per-cycle comparison shows it.

// File: rtl/sarPkg.sv
package sarPkg;
  typedef struct packed {
    logic load;
    logic resolve;
    logic last;
  } ctrlStrobes_t;
endpackage

// File: rtl/sarControl.sv
module sarControl
  import sarPkg::*;
#(
  parameter int WIDTH = 12,
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startPulse,
  input  logic            clearDone,
  output ctrlStrobes_t    strobes,
  output logic [IDXW-1:0] bitIdx,
  output logic            busy,
  output logic            done
);
  localparam logic [IDXW-1:0] TOPIDX = IDXW'(WIDTH - 1);

  logic accept;
  assign accept = startPulse && !busy;

  always_comb begin
    strobes.load    = accept;
    strobes.resolve = busy;
    strobes.last    = busy && (bitIdx == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      bitIdx <= '0;
      done   <= 1'b0;
    end else if (accept) begin
      busy   <= 1'b1;
      bitIdx <= TOPIDX;
      done   <= 1'b0;
    end else if (busy) begin
      if (bitIdx == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        bitIdx <= bitIdx - IDXW'(1);
      end
    end else if (clearDone) begin
      done <= 1'b0;
    end
  end

  // R7: a start during a conversion neither restarts nor stalls it
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse && bitIdx != '0) |=> (busy && bitIdx == $past(bitIdx) - IDXW'(1)));

  // R8: done rises only out of the last resolution step
  p_done_timing_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(busy) && $past(bitIdx) == '0 && !busy));

  // R9: done holds without a start or clear
  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startPulse && !clearDone) |=> done);

  // R10: clear or an accepted start drops done
  p_done_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (clearDone || (startPulse && !busy)) |=> !done);
endmodule

// File: rtl/sarDatapath.sv
module sarDatapath
  import sarPkg::*;
#(
  parameter int WIDTH = 12,
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [IDXW-1:0]  bitIdx,
  input  logic             cmpAbove,
  output logic [WIDTH-1:0] partialCode,
  output logic [WIDTH-1:0] validMask
);
  localparam logic [WIDTH-1:0] TOPBIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [IDXW-1:0] lowerIdx;
  assign lowerIdx = bitIdx - IDXW'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      partialCode <= '0;
      validMask   <= '0;
    end else if (strobes.load) begin
      partialCode <= TOPBIT;
      validMask   <= '0;
    end else if (strobes.resolve) begin
      partialCode[bitIdx] <= cmpAbove;
      validMask[bitIdx]   <= 1'b1;
      if (!strobes.last) partialCode[lowerIdx] <= 1'b1;
    end
  end

  // R2: an accepted start leaves only the top trial bit and an empty mask
  p_load_state_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (partialCode == TOPBIT && validMask == '0));

  // R3: each resolution adds exactly one mask bit, top bit first
  p_msb_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.resolve |=> ($countones(validMask) == $countones($past(validMask)) + 1
                         && validMask[WIDTH-1]));

  // R4: the fixed bit follows the comparator
  p_bit_decision_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.resolve |=> (partialCode[$past(bitIdx)] == $past(cmpAbove)));

  // R6: final bits never move until the next load
  p_final_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> (((partialCode ^ $past(partialCode)) & $past(validMask)) == '0));

  // R8: the last step completes the mask
  p_full_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.last |=> (&validMask));
endmodule

// File: rtl/sarSequencer.sv
module sarSequencer
  import sarPkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             clearDone,
  input  logic             cmpAbove,
  output logic [WIDTH-1:0] trialCode,
  output logic [WIDTH-1:0] partialCode,
  output logic [WIDTH-1:0] validMask,
  output logic             busy,
  output logic             done
);
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  ctrlStrobes_t    strobes;
  logic [IDXW-1:0] bitIdx;

  sarControl #(.WIDTH(WIDTH)) i_control (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .clearDone(clearDone),
    .strobes(strobes), .bitIdx(bitIdx), .busy(busy), .done(done)
  );

  sarDatapath #(.WIDTH(WIDTH)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bitIdx(bitIdx),
    .cmpAbove(cmpAbove), .partialCode(partialCode), .validMask(validMask)
  );

  assign trialCode = partialCode;

  // R4: the DAC always sees the working register
  p_trial_matches_r4: assert property (@(posedge clk) disable iff (!rstN)
    trialCode == partialCode);
endmodule

// File: tb/test_sarSequencer.sv
`timescale 1ns/1ps
module test_sarSequencer;
  localparam int W = 12;

  typedef struct {
    logic [W-1:0] code;
    logic [W-1:0] mask;
    logic         done;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic clearDone = 1'b0;
  logic cmpAbove;
  logic [W-1:0] trialCode, partialCode, validMask;
  logic busy, done;
  logic [W-1:0] analogIn = '0;

  int compared = 0;
  int mismatched = 0;
  expItem_t sb[$];

  always #5 clk = ~clk;

  // ideal comparator: 1 when the input is at or above the trial code (R4)
  assign cmpAbove = (analogIn >= trialCode);

  sarSequencer #(.WIDTH(W)) i_sarSequencer (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .clearDone(clearDone),
    .cmpAbove(cmpAbove), .trialCode(trialCode), .partialCode(partialCode),
    .validMask(validMask), .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
    end
  endtask

  // monitor: one expected snapshot per cycle (R2 R3 R4 R5 R6 R8)
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        expItem_t e;
        e = sb.pop_front();
        check("R3/R4/R5 code", partialCode, e.code);
        check("R3 mask", validMask, e.mask);
        check("R8 done", W'(done), W'(e.done));
        check("R8 busy", W'(busy), W'(!e.done));
      end
    end
  end

  // driver: starts a conversion, optionally pokes start mid-run (R7)
  task automatic convert(input logic [W-1:0] v, input int pokeAt);
    analogIn = v;
    startPulse = 1'b1;
    @(posedge clk);
    #1 startPulse = 1'b0;
    for (int j = 0; j <= W; j++) begin
      expItem_t e;
      logic [W-1:0] m;
      m = (j == 0) ? '0 : ~((W'(1) << (W - j)) - W'(1));
      e.mask = m;
      e.code = (v & m) | ((j < W) ? (W'(1) << (W - 1 - j)) : '0);
      e.done = (j == W);
      sb.push_back(e);
    end
    for (int j = 1; j <= W; j++) begin
      @(posedge clk);
      #2 startPulse = (j == pokeAt);
    end
    startPulse = 1'b0;
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [W-1:0] lastV;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 code", partialCode, '0);
    check("R11 mask", validMask, '0);
    check("R11 busy/done", {10'd0, busy, done}, '0);
    @(posedge clk); #2 rstN = 1'b1;
    @(posedge clk); #2;

    // R1 R8: corner values with the default 12-bit width
    convert(12'h000, 0);
    convert(12'hFFF, 0);
    convert(12'h800, 0);
    convert(12'h7FF, 0);
    // R7: start pulses in the middle of a run
    convert(12'hA5C, 3);
    convert(12'h3E1, W - 1);
    for (int k = 0; k < 40; k++) convert(W'($urandom), (k % 5 == 0) ? 1 + k % (W - 1) : 0);

    lastV = 12'h6B2;
    convert(lastV, 0);
    @(posedge clk);
    @(negedge clk);
    // R9: done holds with no start or clear
    check("R9 done held", W'(done), W'(1));
    repeat (4) @(negedge clk);
    check("R9 done still held", W'(done), W'(1));
    check("R9 code held", partialCode, lastV);
    // R10: clear drops done, data stays
    @(posedge clk); #2 clearDone = 1'b1;
    @(posedge clk); #1 clearDone = 1'b0;
    @(negedge clk);
    check("R10 done cleared", W'(done), W'(0));
    check("R10 code kept", partialCode, lastV);
    check("R10 mask kept", validMask, '1);
    @(posedge clk); #2;
    convert(12'h001, 0);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule